// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happens. A free-running 16-bit counter outside the block supplies the time base on `cntVal`. One of two event sources is chosen: a device pin or the output of an external comparator. The chosen source passes through a two-flop synchroniser, then an optional four-sample noise filter, then an edge detector set to rising or falling. When a qualifying edge is seen, the counter value is copied into a 16-bit capture register. In the same clock edge a capture flag is set, and this flag can raise an interrupt request.

Software reads the capture register over an 8-bit bus. Reading the low byte also copies the captured high byte into a temporary byte. A later high-byte read returns that temporary byte, so the pair stays consistent even if a new capture lands between the two reads. The flag is cleared by an interrupt acknowledge pulse, or by software writing a one to the flag bit.

Top module: `ecap_top`

## Requirements
- R1: `srcSelCmp` = 0 selects `pinIn` and `srcSelCmp` = 1 selects `cmpIn`. Transitions on the source that is not selected cause no capture and leave `capFlag` at 0.
- R2: `edgeRise` = 1 captures on a 0-to-1 transition and `edgeRise` = 0 captures on a 1-to-0 transition. The opposite transition leaves the flag and the capture register unchanged.
- R3: With the filter off, the captured value is the `cntVal` value present at the third rising clock edge after the source changes: two synchroniser stages plus one edge stage.
- R4: `capFlag` rises at the same clock edge that writes the capture register. It is still 0 one cycle earlier, and only a capture sets it.
- R5: `irq` is 1 exactly when `capFlag` and `intEn` are both 1.
- R6: A one-cycle `intAck` pulse clears `capFlag`.
- R7: A bus write to address 2 with `wrData` bit 0 = 1 clears `capFlag`. A write to address 2 with bit 0 = 0 has no effect.
- R8: If a capture and a clear (software write or `intAck`) happen in the same cycle, the capture wins and `capFlag` stays 1.
- R9: The read addresses are as follows. Address 0 returns the captured bits 7:0 and latches bits 15:8 into the temporary byte. Address 1 returns the temporary byte, which changes only on an address-0 read. Address 2 returns `capFlag` in bit 0 with zeros above it. After reset every byte is 0.
- R10: With `filtEn` = 1, a new level is accepted only after four equal consecutive samples. A capture therefore comes four cycles later than with the filter off, and pulses shorter than four cycles are rejected.
- R11: A capture while `capFlag` is already 1 overwrites the capture register, and `capFlag` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Pin event source |
| cmpIn | input | 1 | Comparator event source |
| srcSelCmp | input | 1 | 1 selects the comparator source |
| filtEn | input | 1 | Enables the four-sample noise filter |
| edgeRise | input | 1 | 1 selects rising edge, 0 selects falling edge |
| intEn | input | 1 | Interrupt enable |
| cntVal | input | 16 | Counter value supplied from outside |
| intAck | input | 1 | Interrupt acknowledge pulse |
| busAddr | input | 2 | Bus byte address (0 low, 1 high, 2 flag) |
| rdEn | input | 1 | Bus read strobe |
| wrEn | input | 1 | Bus write strobe |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data, combinational |
| capFlag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Setting the flag on a capture and clearing it can both fall in the same clock edge. To provoke this, the bench drives a software clear and an acknowledge pulse in exactly the cycle before the edge on which the capture is expected. It computes that edge from the synchroniser latency. The case passes only if the flag reads 1 afterwards and the register holds the counter value of that cycle. A second pairing puts a low-byte read, which loads the temporary byte, before a fresh capture. The bench then requires the later high-byte read to return the old high byte.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef enum logic [1:0] {
    ADDR_LOW  = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } ecapAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdLow;
    logic rdHigh;
    logic rdFlag;
  } ecapStrobes_t;

endpackage

// File: rtl/ecap_filter.sv
module ecap_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic filtEn,
  output logic lvlOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncLvl;
  logic filtLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_filter
      logic [FILT_LEN-2:0] histQ;
      logic [FILT_LEN-1:0] window;
      assign window = {histQ, syncLvl};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          histQ   <= '0;
          filtLvl <= 1'b0;
        end else begin
          histQ <= window[FILT_LEN-2:0];
          if (&window)       filtLvl <= 1'b1;
          else if (~|window) filtLvl <= 1'b0;
        end
      end

      AST_FILT_RISE_AGREES: assert property (@(posedge clk) disable iff (!rstN)
        $rose(filtLvl) |-> $past(syncLvl)); // R10
      AST_FILT_FALL_AGREES: assert property (@(posedge clk) disable iff (!rstN)
        $fell(filtLvl) |-> !$past(syncLvl)); // R10
    end else begin : g_nofilter
      assign filtLvl = syncLvl;
    end
  endgenerate

  assign lvlOut = filtEn ? filtLvl : syncLvl;

endmodule

// File: rtl/ecap_datapath.sv
module ecap_datapath
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             cmpIn,
  input  logic             srcSelCmp,
  input  logic             filtEn,
  input  logic             edgeRise,
  input  logic [CNT_W-1:0] cntVal,
  input  ecapStrobes_t     strb,
  input  logic             flagBit,
  output logic             capStrobe,
  output logic [BUS_W-1:0] rdData
);

  localparam int HI_W = CNT_W - BUS_W;

  logic rawSel;
  logic lvl;
  logic prevLvl;
  logic [CNT_W-1:0] capQ;
  logic [HI_W-1:0]  tempQ;

  assign rawSel = srcSelCmp ? cmpIn : pinIn;

  ecap_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) filter_i (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn (rawSel),
    .filtEn(filtEn),
    .lvlOut(lvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= lvl;
  end

  assign capStrobe = edgeRise ? (lvl & ~prevLvl) : (~lvl & prevLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          capQ <= '0;
    else if (capStrobe) capQ <= cntVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tempQ <= '0;
    else if (strb.rdLow) tempQ <= capQ[CNT_W-1:BUS_W];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdLow)       rdData = capQ[BUS_W-1:0];
    else if (strb.rdHigh) rdData = tempQ[BUS_W-1:0];
    else if (strb.rdFlag) rdData = {{(BUS_W-1){1'b0}}, flagBit};
  end

  AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> (capQ == $past(cntVal))); // R3
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !capStrobe |=> $stable(capQ)); // R2
  AST_TEMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLow |=> $stable(tempQ)); // R9

endmodule

// File: rtl/ecap_control.sv
module ecap_control
  import ecap_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] wrData,
  input  logic             intAck,
  input  logic             intEn,
  input  logic             capStrobe,
  output ecapStrobes_t     strb,
  output logic             capFlag,
  output logic             irq
);

  ecapAddr_t addr;
  logic swClr;
  logic flagQ;
  logic wrUnused;

  assign addr     = ecapAddr_t'(busAddr);
  assign swClr    = wrEn && (addr == ADDR_FLAG) && wrData[0];
  assign wrUnused = ^wrData[BUS_W-1:1];

  assign strb.rdLow  = rdEn && (addr == ADDR_LOW);
  assign strb.rdHigh = rdEn && (addr == ADDR_HIGH);
  assign strb.rdFlag = rdEn && (addr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagQ <= 1'b0;
    else if (capStrobe)         flagQ <= 1'b1;
    else if (swClr || intAck)   flagQ <= 1'b0;
  end

  assign capFlag = flagQ;
  assign irq     = flagQ & intEn;

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> capFlag); // R4
  AST_FLAG_ONLY_BY_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!capStrobe && !capFlag) |=> !capFlag); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !capStrobe) |=> !capFlag); // R6
  AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (swClr && !capStrobe) |=> !capFlag); // R7
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (capStrobe && (swClr || intAck)) |=> capFlag); // R8
  AST_OVERWRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (capStrobe && capFlag) |=> capFlag); // R11

endmodule

// File: rtl/ecap_top.sv
module ecap_top
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             cmpIn,
  input  logic             srcSelCmp,
  input  logic             filtEn,
  input  logic             edgeRise,
  input  logic             intEn,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             intAck,
  input  logic [1:0]       busAddr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  output logic             capFlag,
  output logic             irq
);

  ecapStrobes_t strb;
  logic capStrobe;

  ecap_control #(.BUS_W(BUS_W)) control_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .intAck   (intAck),
    .intEn    (intEn),
    .capStrobe(capStrobe),
    .strb     (strb),
    .capFlag  (capFlag),
    .irq      (irq)
  );

  ecap_datapath #(
    .CNT_W      (CNT_W),
    .BUS_W      (BUS_W),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .cmpIn    (cmpIn),
    .srcSelCmp(srcSelCmp),
    .filtEn   (filtEn),
    .edgeRise (edgeRise),
    .cntVal   (cntVal),
    .strb     (strb),
    .flagBit  (capFlag),
    .capStrobe(capStrobe),
    .rdData   (rdData)
  );

endmodule

// File: tb/ecap_top_tb_top.sv
module ecap_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic        cmpIn = 1'b0;
  logic        srcSelCmp = 1'b0;
  logic        filtEn = 1'b0;
  logic        edgeRise = 1'b1;
  logic        intEn = 1'b0;
  logic [15:0] cntVal = 16'd0;
  logic        intAck = 1'b0;
  logic [1:0]  busAddr = 2'd3;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic        capFlag;
  logic        irq;

  int total = 0;
  int fails = 0;
  int tick = 0;
  logic [15:0] expQ[$];
  logic [15:0] capWord;
  string       capTag;
  event        capReadEv;

  ecap_top dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn),
    .srcSelCmp(srcSelCmp), .filtEn(filtEn), .edgeRise(edgeRise),
    .intEn(intEn), .cntVal(cntVal), .intAck(intAck), .busAddr(busAddr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .capFlag(capFlag), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] cntAt(input int t);
    return 16'(t * 301 + 17);
  endfunction

  initial forever begin
    @(posedge clk);
    #1;
    tick++;
    cntVal = cntAt(tick);
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(capReadEv) begin
    if (expQ.size() == 0) check({capTag, " (no expected item)"}, capWord, 16'hdead);
    else check(capTag, capWord, expQ.pop_front());
  end

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: change a source, push expected capture if one should follow
  task automatic srcEdge(input bit useCmp, input bit val, input int lat, input bit expCap);
    @(negedge clk);
    if (useCmp) cmpIn = val; else pinIn = val;
    if (expCap) expQ.push_back(cntAt(tick + lat));
  endtask

  task automatic readCap(input string tag);
    logic [7:0] lo;
    logic [7:0] hi;
    @(negedge clk);
    busAddr = 2'd0; rdEn = 1'b1;
    #1 lo = rdData;
    @(negedge clk);
    busAddr = 2'd1;
    #1 hi = rdData;
    rdEn = 1'b0; busAddr = 2'd3;
    capWord = {hi, lo};
    capTag = tag;
    ->capReadEv;
  endtask

  task automatic busWrite(input logic [7:0] d);
    @(negedge clk);
    busAddr = 2'd2; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; busAddr = 2'd3; wrData = 8'd0;
  endtask

  task automatic readFlagReg(input string tag, input int exp);
    @(negedge clk);
    busAddr = 2'd2; rdEn = 1'b1;
    #1 check(tag, rdData, exp);
    rdEn = 1'b0; busAddr = 2'd3;
  endtask

  logic [15:0] lastA;
  logic [7:0]  byteVal;

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    // reset state
    check("R4 reset flag", capFlag, 0);
    check("R5 reset irq", irq, 0);
    expQ.push_back(16'd0);
    readCap("R9 reset capture value");
    waitNeg(2);

    // basic rising capture on pin
    srcEdge(1'b0, 1'b1, 2, 1'b1);
    waitNeg(2);
    check("R4 flag not early", capFlag, 0);
    waitNeg(1);
    check("R4 flag with capture", capFlag, 1);
    check("R5 irq masked", irq, 0);
    readCap("R3 captured count");
    @(negedge clk); intEn = 1'b1;
    #1 check("R5 irq enabled", irq, 1);
    readFlagReg("R9 flag byte", 1);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    check("R6 ack clears", capFlag, 0);
    check("R5 irq after ack", irq, 0);

    // polarity: falling edge ignored with rising selected
    lastA = cntAt(tick - 0);
    srcEdge(1'b0, 1'b0, 0, 1'b0);
    waitNeg(6);
    check("R2 opposite edge ignored", capFlag, 0);
    @(negedge clk); edgeRise = 1'b0;
    srcEdge(1'b0, 1'b1, 0, 1'b0);
    waitNeg(6);
    check("R2 rising ignored in falling mode", capFlag, 0);
    srcEdge(1'b0, 1'b0, 2, 1'b1);
    waitNeg(4);
    check("R2 falling captured", capFlag, 1);
    readCap("R2 falling capture value");
    busWrite(8'h01);

    // source select: pin ignored when comparator selected
    @(negedge clk); srcSelCmp = 1'b1; edgeRise = 1'b1;
    srcEdge(1'b0, 1'b1, 0, 1'b0);
    waitNeg(6);
    check("R1 unselected pin ignored", capFlag, 0);
    srcEdge(1'b0, 1'b0, 0, 1'b0);
    waitNeg(6);
    check("R1 unselected pin ignored again", capFlag, 0);
    srcEdge(1'b1, 1'b1, 2, 1'b1);
    waitNeg(4);
    check("R1 comparator captured", capFlag, 1);
    readCap("R1 comparator value");

    // software clear
    busWrite(8'hFE);
    check("R7 write zero no effect", capFlag, 1);
    busWrite(8'h01);
    check("R7 write one clears", capFlag, 0);

    // overwrite while flag set
    @(negedge clk); edgeRise = 1'b0;
    srcEdge(1'b1, 1'b0, 2, 1'b0);
    waitNeg(4);
    check("R11 first capture", capFlag, 1);
    srcEdge(1'b1, 1'b1, 0, 1'b0);
    waitNeg(4);
    srcEdge(1'b1, 1'b0, 2, 1'b1);
    waitNeg(4);
    check("R11 flag stays set", capFlag, 1);
    readCap("R11 register overwritten");
    busWrite(8'h01);

    // capture and clear in the same cycle
    @(negedge clk); edgeRise = 1'b1;
    srcEdge(1'b1, 1'b1, 2, 1'b1);
    waitNeg(1);
    @(negedge clk);
    busAddr = 2'd2; wrEn = 1'b1; wrData = 8'h01; intAck = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; intAck = 1'b0; busAddr = 2'd3; wrData = 8'd0;
    check("R8 capture beats clear", capFlag, 1);
    readCap("R8 capture value");

    // atomic read: low read latches high byte, later capture does not disturb it
    lastA = expQ.size() == 0 ? 16'd0 : 16'd0;
    srcEdge(1'b1, 1'b0, 0, 1'b0);
    waitNeg(4);
    srcEdge(1'b1, 1'b1, 2, 1'b0);
    lastA = cntAt(tick + 2);
    waitNeg(4);
    @(negedge clk); busAddr = 2'd0; rdEn = 1'b1;
    #1 check("R9 low byte", rdData, lastA[7:0]);
    @(negedge clk); rdEn = 1'b0; busAddr = 2'd3;
    srcEdge(1'b1, 1'b0, 0, 1'b0);
    waitNeg(4);
    srcEdge(1'b1, 1'b1, 2, 1'b1);
    waitNeg(4);
    @(negedge clk); busAddr = 2'd1; rdEn = 1'b1;
    #1 byteVal = rdData;
    rdEn = 1'b0; busAddr = 2'd3;
    check("R9 high byte from latch", byteVal, lastA[15:8]);
    readCap("R9 new capture pair");
    busWrite(8'h01);

    // filter: short pulses rejected, held level delayed by four cycles
    srcEdge(1'b1, 1'b0, 0, 1'b0);
    waitNeg(6);
    @(negedge clk); filtEn = 1'b1;
    waitNeg(6);
    srcEdge(1'b1, 1'b1, 0, 1'b0);
    waitNeg(2);
    cmpIn = 1'b0;
    waitNeg(12);
    check("R10 two-cycle pulse rejected", capFlag, 0);
    srcEdge(1'b1, 1'b1, 0, 1'b0);
    waitNeg(3);
    cmpIn = 1'b0;
    waitNeg(12);
    check("R10 three-cycle pulse rejected", capFlag, 0);
    srcEdge(1'b1, 1'b1, 6, 1'b1);
    waitNeg(6);
    check("R10 flag not before filter delay", capFlag, 0);
    waitNeg(1);
    check("R10 flag after filter delay", capFlag, 1);
    readCap("R10 filtered capture value");

    waitNeg(2);
    check("scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule